// File: doc/BRIEF.md
# Binary-to-Residue Forward Converter

This block takes an unsigned binary word of Q·N bits and returns its remainder modulo one fixed modulus. The modulus is chosen when the block is built. It can be 2^N − K, 2^N + K or 2^N. The word is cut into Q slices of N bits. Slice j is multiplied by a constant weight equal to 2^(j·N) mod m and the product is reduced. The reduced terms are summed one slice per clock, and every partial sum is brought back into [0, m) before the next term is added. No table of residues is stored anywhere: the weights are computed from the parameters during elaboration.

A conversion starts when `start` is high while `ready` is high. The converter then works through the slices for Q cycles. It raises `done` for a single cycle, and `residue` holds the result until the next conversion finishes. To build a three-channel front end for the moduli {2^N − K, 2^N, 2^N + K}, place three copies side by side, each with a different `SIGN`.

Top module: `rns_fwd_conv`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, `done` is 0, `ready` is 1 and `residue` is 0.
- R2: With SIGN = −1, the residue reported at `done` equals word mod (2^N − K) for every input word.
- R3: With SIGN = +1, the residue reported at `done` equals word mod (2^N + K) for every input word.
- R4: The case K = 1 is handled by the same datapath, for both signs: moduli 2^N − 1 and 2^N + 1.
- R5: With SIGN = 0, the modulus is 2^N and the residue equals the low N bits of the word.
- R6: `done` rises on the Q-th rising edge after the edge that accepts `start`, and it stays high for exactly one cycle.
- R7: `ready` is 0 from the accepting edge until the edge that raises `done`. A `start` pulse while `ready` is 0 is ignored: the result and the timing of the conversion in flight are unchanged, and no extra `done` follows.
- R8: `residue` always lies in [0, m). It changes only on the edge that raises `done`.
- R9: The edge inputs give the exact values: word 0 gives 0, the all-ones word gives (2^(Q·N) − 1) mod m, and every exact multiple of m gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a conversion of `word_in` |
| word_in | input | Q*N | Unsigned binary operand, sampled on the accepting edge |
| ready | output | 1 | High when a new `start` will be accepted |
| done | output | 1 | One-cycle pulse when `residue` holds a new result |
| residue | output | N+1 | Remainder of the last accepted word modulo m |

## Verification
The hardest case to reach from the ports is a weighted slice product that lands exactly on a multiple of m, combined with an accumulator sitting just below m. In that case the modular adder must wrap at precisely m and not one step off. Random wide words seldom produce it. The bench therefore uses a small configuration (N = 4, Q = 3) and sweeps every one of the 4096 input words through five parallel instances (m = 13, 19, 15, 17 and 16), which forces every accumulator/term pairing. The default wide instance is then driven with zero, all ones, a run of exact multiples of m, random words, and a `start` issued mid-conversion.

// File: rtl/rns_fwd_pkg.sv
package rns_fwd_pkg;

  // Modulus selected by the sign: -1 -> 2^n-k, +1 -> 2^n+k, 0 -> 2^n
  function automatic longint unsigned modulus_of(int n, int k, int sign);
    longint signed base;
    base = longint'(1) <<< n;
    return longint'(base + longint'(sign) * longint'(k));
  endfunction

  // Weight of slice j: 2^(j*n) mod m, built up one slice shift at a time
  function automatic longint unsigned weight_of(int n, int k, int sign, int j);
    longint unsigned m;
    longint unsigned w;
    m = modulus_of(n, k, sign);
    w = 64'd1 % m;
    for (int i = 0; i < j; i++) w = (w << n) % m;
    return w;
  endfunction

endpackage

// File: rtl/rns_term.sv
// One weighted slice: (chunk * weight) mod m, purely combinational
module rns_term #(
  parameter int N    = 8,
  parameter int K    = 3,
  parameter int SIGN = -1
) (
  input  logic [N-1:0] chunk,
  input  logic [N:0]   weight,
  output logic [N:0]   term
);
  localparam int MW = N + 1;
  localparam int PW = N + MW;
  localparam logic [PW-1:0] MOD_P = PW'(rns_fwd_pkg::modulus_of(N, K, SIGN));

  generate
    if (SIGN == 0) begin : g_pow2
      // weights are 1 for the lowest slice and 0 above it
      assign term = weight[0] ? {1'b0, chunk} : '0;
    end else begin : g_general
      logic [PW-1:0] prod;
      logic [PW-1:0] red;
      always_comb begin
        prod = PW'(chunk) * PW'(weight);
        red  = prod % MOD_P;
        term = red[MW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/rns_mod_add.sv
// (a + b) mod m for a, b already in [0, m)
module rns_mod_add #(
  parameter int N    = 8,
  parameter int K    = 3,
  parameter int SIGN = -1
) (
  input  logic [N:0] a,
  input  logic [N:0] b,
  output logic [N:0] sum
);
  localparam int MW = N + 1;
  localparam logic [MW:0] MOD_S = (MW+1)'(rns_fwd_pkg::modulus_of(N, K, SIGN));

  logic [MW:0] raw;
  logic        wrap;

  always_comb begin
    raw  = {1'b0, a} + {1'b0, b};
    wrap = (raw >= MOD_S);
    sum  = wrap ? MW'(raw - MOD_S) : raw[MW-1:0];
  end

  // R8: the sum of two in-range operands stays in range
  always_comb begin
    if ({1'b0, a} < MOD_S && {1'b0, b} < MOD_S)
      assert_sum_in_range_R8: assert ({1'b0, sum} < MOD_S);
  end
endmodule

// File: rtl/rns_fwd_conv.sv
module rns_fwd_conv #(
  parameter int N    = 8,
  parameter int Q    = 4,
  parameter int K    = 3,
  parameter int SIGN = -1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [Q*N-1:0] word_in,
  output logic           ready,
  output logic           done,
  output logic [N:0]     residue
);
  localparam int MW = N + 1;
  localparam int IW = (Q > 1) ? $clog2(Q) : 1;
  localparam logic [MW-1:0] MOD = MW'(rns_fwd_pkg::modulus_of(N, K, SIGN));
  localparam logic [IW-1:0] LAST_IDX = IW'(Q - 1);

  logic [MW-1:0] weight_tab [Q];
  generate
    for (genvar j = 0; j < Q; j++) begin : g_weight
      assign weight_tab[j] = MW'(rns_fwd_pkg::weight_of(N, K, SIGN, j));
    end
  endgenerate

  logic           busy;
  logic [IW-1:0]  idx;
  logic [Q*N-1:0] shreg;
  logic [MW-1:0]  acc;
  logic [MW-1:0]  res_q;
  logic           done_q;

  // named events for the assertions
  logic           accept;
  logic           last_step;
  logic [N-1:0]   chunk;
  logic [MW-1:0]  cur_weight;
  logic [MW-1:0]  term;
  logic [MW-1:0]  next_acc;

  assign accept     = start & ~busy;
  assign last_step  = busy & (idx == LAST_IDX);
  assign chunk      = shreg[N-1:0];
  assign cur_weight = weight_tab[idx];

  rns_term #(.N(N), .K(K), .SIGN(SIGN)) u_term (
    .chunk  (chunk),
    .weight (cur_weight),
    .term   (term)
  );

  rns_mod_add #(.N(N), .K(K), .SIGN(SIGN)) u_add (
    .a   (acc),
    .b   (term),
    .sum (next_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      shreg  <= '0;
      acc    <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        idx   <= '0;
        shreg <= word_in;
        acc   <= '0;
      end else if (busy) begin
        acc   <= next_acc;
        shreg <= shreg >> N;
        idx   <= idx + 1'b1;
        if (last_step) begin
          busy   <= 1'b0;
          res_q  <= next_acc;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign ready   = ~busy;
  assign done    = done_q;
  assign residue = res_q;

  // R8: a reported residue is below the modulus
  assert_residue_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> residue < MOD);

  // R8: the result register moves only with done
  assert_residue_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(residue));

  // R6: done is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: an accepted start drops ready on the next cycle
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R6: done follows the final slice step
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

  // R2: the running partial sum never leaves [0, m)
  assert_acc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> acc < MOD);
endmodule

// File: tb/tb_rns_fwd_conv.sv
module tb_rns_fwd_conv;
  localparam int N  = 8;
  localparam int Q  = 4;
  localparam int K  = 3;
  localparam longint unsigned M = 64'd253;   // 2^8 - 3

  localparam int SN = 4;
  localparam int SQ = 3;
  localparam int NS = 5;
  localparam int KS [NS] = '{3, 3, 1, 1, 0};
  localparam int SG [NS] = '{-1, 1, -1, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  int vectors = 0;
  int miscompares = 0;

  // wide default instance
  logic           start = 1'b0;
  logic [Q*N-1:0] word = '0;
  logic           ready, done;
  logic [N:0]     residue;

  rns_fwd_conv dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word),
    .ready(ready), .done(done), .residue(residue)
  );

  // small instances swept exhaustively
  logic             s_start = 1'b0;
  logic [SQ*SN-1:0] s_word = '0;
  logic             s_ready [NS];
  logic             s_done  [NS];
  logic [SN:0]      s_res   [NS];

  generate
    for (genvar g = 0; g < NS; g++) begin : g_small
      rns_fwd_conv #(.N(SN), .Q(SQ), .K(KS[g]), .SIGN(SG[g])) u_small (
        .clk(clk), .rst_n(rst_n), .start(s_start), .word_in(s_word),
        .ready(s_ready[g]), .done(s_done[g]), .residue(s_res[g])
      );
    end
  endgenerate

  task automatic check(string req, longint unsigned got, longint unsigned exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic string req_of(int g);
    if (SG[g] == 0) return "R5";
    if (KS[g] == 1) return "R4";
    return (SG[g] < 0) ? "R2" : "R3";
  endfunction

  task automatic run_small(int x);
    @(negedge clk);
    s_word  = (SQ*SN)'(x);
    s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    for (int c = 1; c <= SQ; c++) begin
      @(negedge clk);
      for (int g = 0; g < NS; g++) begin
        longint unsigned m = longint'(16 + SG[g] * KS[g]);
        if (c == SQ) begin
          check("R6", s_done[g], 1);
          check(req_of(g), s_res[g], longint'(x) % m);
        end else if (c == SQ - 1) begin
          check("R6", s_done[g], 0);
        end else if (c == 1 && x == 0) begin
          check("R7", s_ready[g], 0);
        end
      end
    end
  endtask

  // wide conversion; optionally fires a stray start mid-flight
  task automatic run_wide(longint unsigned x, string req, bit stray);
    @(negedge clk);
    word  = (Q*N)'(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= Q + 1; c++) begin
      @(negedge clk);
      if (c == 1) begin
        check("R7", ready, 0);
        if (stray) begin
          word  = ~word;
          start = 1'b1;
        end
      end else begin
        start = 1'b0;
      end
      if (c == Q - 1) check("R6", done, 0);
      if (c == Q) begin
        check("R6", done, 1);
        check("R7", ready, 1);
        check(req, residue, x % M);
        check("R8", residue < M, 1);
      end
      if (c == Q + 1) begin
        check(stray ? "R7" : "R6", done, 0);
        check("R8", residue, x % M);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", done, 0);
    check("R1", ready, 1);
    check("R1", residue, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", done, 0);
    check("R1", ready, 1);
    check("R1", residue, 0);

    // R2 R3 R4 R5: every small word on all five moduli
    for (int x = 0; x < (1 << (SQ*SN)); x++) run_small(x);

    // R9 edge values on the wide instance
    run_wide(64'd0, "R9", 1'b0);
    run_wide(64'hFFFF_FFFF, "R9", 1'b0);
    for (int c = 1; c <= 40; c++)
      run_wide(M * longint'(c) * 64'd104729 % (64'd1 << 32) / M * M, "R9", 1'b0);
    run_wide((64'hFFFF_FFFF / M) * M, "R9", 1'b0);

    // R2 random words
    for (int i = 0; i < 300; i++) run_wide(longint'($urandom), "R2", 1'b0);

    // R7 stray start during a conversion
    for (int i = 0; i < 20; i++) run_wide(longint'($urandom), "R7", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule